// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one channel of a memory-mapped up-counting timer. Software programs it over a plain single-cycle register bus. A clock-control register sets an optional power-of-two prescaler and picks the count source: either every clock cycle, or only the cycles in which a synchronous external tick input is high. A counter-control register stops and starts the count, chooses between free-running and interval operation, and restarts the count from zero.

In interval mode the count climbs to a programmed limit, returns to zero on the next tick and raises an interval event. In free-running mode it rolls over at all-ones and raises an overflow event. Events are latched in a status register that clears when it is read. A level interrupt output is high while any latched event is unmasked by the enable register.

Up to three channels can sit side by side. The channel index parameter moves every register of this channel 4 bytes further up per index. The data bus is as wide as the counter, which is 16 or 32 bits.

Top module: `tmr_chan`

## Requirements
- R1: After reset, clock control reads 0x00, counter control reads 0x21 (counter stopped), the interval reads all-ones, status and enable read 0, the count reads 0 and irq is low.
- R2: With channel index k, the registers sit at byte offsets 0x00 (clock control), 0x0C (counter control), 0x18 (count, read-only), 0x24 (interval), 0x54 (status, read-only) and 0x60 (enable), each plus 4*k. Any other address reads 0. A write to the count address leaves the count unchanged.
- R3: In clock control, bit 0 enables the prescaler and bits 4:1 hold N. With the prescaler enabled, the count advances once every 2^(N+1) source ticks; N=2 gives 8 and N=10 gives 2048. With the prescaler disabled, it advances on every source tick whatever N is.
- R4: Clock control bit 5 set to 0 makes every clock cycle a source tick. Set to 1, only cycles with ext_tick high are source ticks. The bit reads back as written.
- R5: Counter control bit 0 set to 1 holds the count. Clearing it resumes counting from the held value on the following cycles.
- R6: A counter-control write with bit 4 set makes the count 0 and restarts the prescaler. Bit 4 reads back as 0, and the other bits of the same write take effect.
- R7: Counter control bit 1 selects interval mode. The count runs 0..interval, returns to 0 on the next tick and sets status bit 0 in that cycle.
- R8: With bit 1 clear, the count rolls over from all-ones to 0 and sets status bit 1.
- R9: A status read returns the latched flags and clears them. Status bits 5:2 and all higher bits read 0.
- R10: If an event occurs in the same cycle as a status read, its flag is set after that cycle.
- R11: irq is high exactly while some status bit and the matching bit of enable (bits 5:0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; data is taken at the clock edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | 8 | Byte address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, 0 when rd_en is low |
| ext_tick | input | 1 | External count source, synchronous to clk |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that ext_tick is already synchronous to clk, and that a read and a write are never issued in the same cycle. The wrap check also assumes that the interval is not rewritten below the running count while interval mode is active. The bench keeps to these limits: it drives one strobe per bus cycle, and it changes ext_tick and bus signals only on the falling edge. It also stops the counter before it reprograms the interval or the prescaler.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CLK  = 'h00;
  localparam int unsigned OFF_CTL  = 'h0C;
  localparam int unsigned OFF_CNT  = 'h18;
  localparam int unsigned OFF_IVAL = 'h24;
  localparam int unsigned OFF_ST   = 'h54;
  localparam int unsigned OFF_IE   = 'h60;
  localparam int unsigned CH_STRIDE = 4;

  localparam int unsigned NFLAG  = 6;
  localparam int unsigned FL_IVL = 0;
  localparam int unsigned FL_OVF = 1;

  localparam int unsigned EXPW = 4;
  localparam logic [5:0] CTL_RESET = 6'h21;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned EXPW = 4
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            src_sel,
  input  logic            ext_tick,
  input  logic            pre_en,
  input  logic [EXPW-1:0] pre_exp,
  input  logic            run,
  input  logic            clr,
  output logic            tick
);
  localparam int unsigned PW = (1 << EXPW) + 1;

  logic [PW-1:0] pc_q, pc_d, div_m1;
  logic          adv;

  always_comb begin
    div_m1 = (PW'(2) << pre_exp) - PW'(1);
    adv    = run && (src_sel ? ext_tick : 1'b1);
    tick   = adv && (!pre_en || (pc_q >= div_m1));
    pc_d   = pc_q;
    if (clr)
      pc_d = '0;
    else if (adv && pre_en)
      pc_d = tick ? '0 : pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  // R4: with the external source chosen, no tick without ext_tick
  p_src_gate_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_sel && !ext_tick) |-> !tick);

  // R3: a prescaled tick is never followed by another in the next cycle
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && pre_en) |=> !(tick && pre_en));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             clr,
  input  logic             ival_mode,
  input  logic [WIDTH-1:0] ival,
  output logic [WIDTH-1:0] cnt,
  output logic             iv_evt,
  output logic             ov_evt
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step   = tick && !clr;
    iv_evt = step && ival_mode && (cnt_q == ival);
    ov_evt = step && !ival_mode && (&cnt_q);
    cnt_d  = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (iv_evt)
      cnt_d = '0;
    else if (step)
      cnt_d = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: an interval event returns the count to zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    iv_evt |=> (cnt == '0));

  // R8: an overflow event leaves the count at zero
  p_roll_zero_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ov_evt |=> (cnt == '0));

  // R6: a restart request zeroes the count
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (cnt == '0));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NB = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [NB-1:0] evt,
  input  logic          rd_clr,
  input  logic [NB-1:0] ie,
  output logic [NB-1:0] st,
  output logic          irq
);
  logic [NB-1:0] st_q, st_d;

  always_comb begin
    st_d = (rd_clr ? '0 : st_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st  = st_q;
  assign irq = |(st_q & ie);

  // R10: a fresh event is always latched, even during a clearing read
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (|evt) |=> ((st & $past(evt)) == $past(evt)));

  // R9: a read with no new event leaves status empty
  p_clear_read_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_clr && (evt == '0)) |=> (st == '0));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned AW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             ext_tick,
  output logic             irq
);
  localparam int unsigned BASE = CH_STRIDE * CH_IDX;
  localparam logic [AW-1:0] A_CLK  = AW'(OFF_CLK  + BASE);
  localparam logic [AW-1:0] A_CTL  = AW'(OFF_CTL  + BASE);
  localparam logic [AW-1:0] A_CNT  = AW'(OFF_CNT  + BASE);
  localparam logic [AW-1:0] A_IVAL = AW'(OFF_IVAL + BASE);
  localparam logic [AW-1:0] A_ST   = AW'(OFF_ST   + BASE);
  localparam logic [AW-1:0] A_IE   = AW'(OFF_IE   + BASE);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [5:0]       clk_q, clk_d, ctl_q, ctl_d, ie_q, ie_d;
  logic [WIDTH-1:0] ival_q, ival_d, cnt;
  logic [NFLAG-1:0] st, evt;
  logic             hit_clk, hit_ctl, hit_cnt, hit_ival, hit_st, hit_ie;
  logic             cnt_clr, rd_clr, tick, iv_evt, ov_evt;

  always_comb begin
    hit_clk  = (addr == A_CLK);
    hit_ctl  = (addr == A_CTL);
    hit_cnt  = (addr == A_CNT);
    hit_ival = (addr == A_IVAL);
    hit_st   = (addr == A_ST);
    hit_ie   = (addr == A_IE);

    clk_d  = (wr_en && hit_clk)  ? wdata[5:0] : clk_q;
    ctl_d  = (wr_en && hit_ctl)  ? {wdata[5], 1'b0, wdata[3:0]} : ctl_q;
    ie_d   = (wr_en && hit_ie)   ? wdata[5:0] : ie_q;
    ival_d = (wr_en && hit_ival) ? wdata : ival_q;

    cnt_clr = wr_en && hit_ctl && wdata[4];
    rd_clr  = rd_en && hit_st;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      clk_q  <= '0;
      ctl_q  <= CTL_RESET;
      ie_q   <= '0;
      ival_q <= '1;
    end else begin
      clk_q  <= clk_d;
      ctl_q  <= ctl_d;
      ie_q   <= ie_d;
      ival_q <= ival_d;
    end
  end

  tmr_prescale #(.EXPW(EXPW)) u_pre (
    .clk      (clk),
    .rst_ni   (rst_q),
    .src_sel  (clk_q[5]),
    .ext_tick (ext_tick),
    .pre_en   (clk_q[0]),
    .pre_exp  (clk_q[4:1]),
    .run      (!ctl_q[0]),
    .clr      (cnt_clr),
    .tick     (tick)
  );

  tmr_count #(.WIDTH(WIDTH)) u_cnt (
    .clk       (clk),
    .rst_ni    (rst_q),
    .tick      (tick),
    .clr       (cnt_clr),
    .ival_mode (ctl_q[1]),
    .ival      (ival_q),
    .cnt       (cnt),
    .iv_evt    (iv_evt),
    .ov_evt    (ov_evt)
  );

  always_comb begin
    evt         = '0;
    evt[FL_IVL] = iv_evt;
    evt[FL_OVF] = ov_evt;
  end

  tmr_irq #(.NB(NFLAG)) u_irq (
    .clk    (clk),
    .rst_ni (rst_q),
    .evt    (evt),
    .rd_clr (rd_clr),
    .ie     (ie_q),
    .st     (st),
    .irq    (irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_clk)       rdata = WIDTH'(clk_q);
      else if (hit_ctl)  rdata = WIDTH'(ctl_q);
      else if (hit_cnt)  rdata = cnt;
      else if (hit_ival) rdata = ival_q;
      else if (hit_st)   rdata = WIDTH'(st);
      else if (hit_ie)   rdata = WIDTH'(ie_q);
    end
  end

  // R5: a stopped counter keeps its value unless restarted
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl_q[0] && !cnt_clr) |=> $stable(cnt));

  // R11: no interrupt while the enable register is empty
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (ie_q == '0) |-> !irq);
endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ext_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  // channel index 1: every offset moves up by 4
  localparam logic [7:0] RCLK = 8'h04, RCTL = 8'h10, RCNT = 8'h1C;
  localparam logic [7:0] RIVL = 8'h28, RST = 8'h58, RIE = 8'h64;

  always #5 clk = ~clk;

  tmr_chan #(.WIDTH(16), .CH_IDX(1), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 clock control", RCLK, 16'h0000);
    rd_chk("R1 counter control", RCTL, 16'h0021);
    rd_chk("R1 interval", RIVL, 16'hFFFF);
    rd_chk("R1 status", RST, 16'h0000);
    rd_chk("R1 enable", RIE, 16'h0000);
    idle(5);
    rd_chk("R1 count stopped", RCNT, 16'h0000);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map;
    rd_chk("R2 unmapped base", 8'h00, 16'h0000);
    rd_chk("R2 unmapped gap", 8'h30, 16'h0000);
    wr(RCNT, 16'h1234);
    rd_chk("R2 count read-only", RCNT, 16'h0000);
  endtask

  task automatic t_free_and_hold;
    wr(RCTL, 16'h0010);
    rd_chk("R6 count restarted", RCNT, 16'h0000);
    idle(7);
    rd_chk("R5 running count", RCNT, 16'd8);
    rd_chk("R6 reset bit reads 0", RCTL, 16'h0000);
    wr(RCTL, 16'h0010);
    idle(9);
    wr(RCTL, 16'h0001);
    idle(20);
    rd_chk("R5 held value", RCNT, 16'd10);
    wr(RCNT, 16'h0000);
    rd_chk("R2 write to count ignored", RCNT, 16'd10);
    wr(RCTL, 16'h0000);
    idle(5);
    rd_chk("R5 resumed from held", RCNT, 16'd15);
    wr(RCTL, 16'h0013);
    rd_chk("R6 other bits applied", RCTL, 16'h0003);
    idle(5);
    rd_chk("R6 zeroed and stopped", RCNT, 16'h0000);
  endtask

  task automatic t_prescale;
    wr(RCLK, 16'h0005);
    wr(RCTL, 16'h0010);
    idle(20);
    rd_chk("R3 divide by 8", RCNT, 16'd2);
    rd_chk("R3 clock control readback", RCLK, 16'h0005);
    wr(RCTL, 16'h0001);
    wr(RCLK, 16'h0015);
    wr(RCTL, 16'h0010);
    idle(4095);
    rd_chk("R3 divide 2048 before second tick", RCNT, 16'd1);
    rd_chk("R3 divide 2048 second tick", RCNT, 16'd2);
    wr(RCTL, 16'h0001);
    wr(RCLK, 16'h0014);
    wr(RCTL, 16'h0010);
    idle(4);
    rd_chk("R3 prescaler off ignores N", RCNT, 16'd4);
  endtask

  task automatic t_source;
    wr(RCTL, 16'h0001);
    wr(RCLK, 16'h0020);
    wr(RCTL, 16'h0010);
    ext_tick = 1'b1;
    idle(3);
    ext_tick = 1'b0;
    idle(5);
    rd_chk("R4 counts ext_tick only", RCNT, 16'd3);
    rd_chk("R4 select readback", RCLK, 16'h0020);
    wr(RCTL, 16'h0001);
    wr(RCLK, 16'h0000);
  endtask

  task automatic t_interval;
    logic [15:0] v;
    rd(RST, v);
    wr(RIVL, 16'd5);
    wr(RIE, 16'h0001);
    wr(RCTL, 16'h0012);
    idle(5);
    rd_chk("R7 count at limit", RCNT, 16'd5);
    chk("R11 irq on interval", {31'h0, irq}, 32'h1);
    rd_chk("R7 interval flag", RST, 16'h0001);
    rd_chk("R9 cleared by read", RST, 16'h0000);
    chk("R11 irq drops after clear", {31'h0, irq}, 32'h0);
    rd_chk("R7 wrapped count", RCNT, 16'd2);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    wr(RCTL, 16'h0001);
    rd(RST, v);
    wr(RIVL, 16'd3);
    wr(RCTL, 16'h0012);
    idle(3);
    rd_chk("R10 read before event", RST, 16'h0000);
    rd_chk("R10 event beats clear", RST, 16'h0001);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    wr(RCTL, 16'h0001);
    rd(RST, v);
    rd(RST, v);
    wr(RIE, 16'h0002);
    wr(RCTL, 16'h0010);
    idle(65535);
    rd_chk("R8 count at all-ones", RCNT, 16'hFFFF);
    chk("R11 irq on overflow", {31'h0, irq}, 32'h1);
    rd_chk("R8 overflow flag, R9 upper bits 0", RST, 16'h0002);
    rd_chk("R8 rolled over", RCNT, 16'd1);
    chk("R11 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_map();
    t_free_and_hold();
    t_prescale();
    t_source();
    t_interval();
    t_collide();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule